// File: doc/BRIEF.md
# Debounced Keypad Matrix Scanner

This block scans a switch matrix of up to eight row lines and ten column lines. Rows are pulled up externally. A pressed switch shorts its row to its column. Two enable masks choose which rows and columns belong to the keypad. Lines outside the masks are never driven and never read.

While nothing is pressed the scanner sits idle. In that state it drives every enabled column low and watches the rows. A low level on any enabled row raises a one-cycle wake pulse. It then starts a sweep that repeats once per scan period. Each sweep drives one column low at a time, in ascending order, and samples the rows in ascending order.

Each key keeps two bits of state: a debounced state and the previous raw sample. A change is reported only after two matching samples in a row. Reports leave the block as one-cycle event pulses that carry a key code and a press/release flag. When no key is held and nothing is pending, the scanner goes back to idle.

Top module: `kp_scanner`

## Requirements
- R1: A row whose `row_en` bit is 0, or a column whose `col_en` bit is 0, never causes a wake pulse or an event. A disabled column is never driven low (`col_drv_n` bit = 1).
- R2: Reset leaves `col_drv_n` all ones with `wake` and `evt_valid` low. In idle, every enabled column is driven low (`col_drv_n` bit = 0) and every disabled column is high. An enabled row held low makes `wake` pulse high for exactly one cycle, two clock edges later.
- R3: A press event is issued only when two consecutive sweeps see the key closed. A key seen closed in one sweep only produces no event. From idle, the press event follows the press by no less than one scan period and no more than one period plus one sweep.
- R4: A key held for many periods produces exactly one press event and no repeats.
- R5: A release event is issued when two consecutive sweeps see a registered key open. It appears between one and two scan periods after the key opens.
- R6: An event is a one-cycle `evt_valid` pulse. `evt_press` = 1 marks a press and 0 marks a release. `evt_code` = row×NCOL + column + 1, which gives 1 to 80 for 8×10. For example, row 1 column 1 gives 12 and row 7 column 9 gives 80.
- R7: Within one sweep, events come in detection order: ascending column first, then ascending row within a column.
- R8: During a sweep, at most one column is driven low at a time. Sweeps start every `TICK_DIV` cycles. After a sweep that leaves no registered key and no pending raw sample, the block returns to idle drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_en | input | NROW | Row participation mask |
| col_en | input | NCOL | Column participation mask |
| row_in | input | NROW | Row levels, low when shorted to a driven column |
| col_drv_n | output | NCOL | Column drive, 0 = driven low, 1 = released |
| wake | output | 1 | One-cycle pulse when idle ends |
| evt_valid | output | 1 | Event strobe |
| evt_press | output | 1 | 1 = press, 0 = release |
| evt_code | output | CODE_W | Key code, row×NCOL+column+1 |

## Verification
The tightest case is one sweep that must report one key's press and another key's release. The bench provokes it by opening one held key and closing another at the same instant. Two sweeps later, the press of the lower column and the release of the higher column must both appear in column order within that single sweep.

A second collision is the end-of-sweep return to idle meeting a fresh row-low. The reference model judges it cycle by cycle through the exact cycle of the following wake pulse.

// File: rtl/kp_pkg.sv
package kp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_SAMPLE,
    ST_EVAL,
    ST_END,
    ST_WAIT
  } kp_state_t;
endpackage

// File: rtl/kp_tick.sv
module kp_tick #(
  parameter int DIV = 6250000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tc
);
  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [TW-1:0] cnt;

  assign tc = (cnt == TW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tc)    cnt <= '0;
    else            cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/kp_keystate.sv
module kp_keystate #(
  parameter int NKEY = 80,
  parameter int IW   = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [IW-1:0] idx,
  input  logic          raw,
  output logic          press_o,
  output logic          rel_o,
  output logic          all_clear
);
  logic [NKEY-1:0] deb;
  logic [NKEY-1:0] prev;
  logic            deb_k;
  logic            prev_k;

  always_comb begin
    deb_k  = 1'b0;
    prev_k = 1'b0;
    for (int i = 0; i < NKEY; i++) begin
      if (idx == IW'(i)) begin
        deb_k  = deb[i];
        prev_k = prev[i];
      end
    end
  end

  assign press_o   = raw & prev_k & ~deb_k;
  assign rel_o     = ~raw & ~prev_k & deb_k;
  assign all_clear = ~|deb & ~|prev;

  for (genvar k = 0; k < NKEY; k++) begin : g_key
    always_ff @(posedge clk) begin
      if (rst) begin
        deb[k]  <= 1'b0;
        prev[k] <= 1'b0;
      end else if (upd && idx == IW'(k)) begin
        prev[k] <= raw;
        if (press_o)    deb[k] <= 1'b1;
        else if (rel_o) deb[k] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/kp_scanner.sv
module kp_scanner
  import kp_pkg::*;
#(
  parameter int NROW     = 8,
  parameter int NCOL     = 10,
  parameter int TICK_DIV = 6250000,
  localparam int NKEY    = NROW * NCOL,
  localparam int CODE_W  = $clog2(NKEY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NROW-1:0]   row_en,
  input  logic [NCOL-1:0]   col_en,
  input  logic [NROW-1:0]   row_in,
  output logic [NCOL-1:0]   col_drv_n,
  output logic              wake,
  output logic              evt_valid,
  output logic              evt_press,
  output logic [CODE_W-1:0] evt_code
);
  localparam int RW = (NROW > 1) ? $clog2(NROW) : 1;
  localparam int CW = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam int IW = (NKEY > 1) ? $clog2(NKEY) : 1;

  kp_state_t     st;
  logic [CW-1:0] col_i;
  logic [RW-1:0] row_i;
  logic [NROW-1:0] row_q;
  logic [NROW-1:0] samp;
  logic [IW-1:0] key_idx;
  logic          tick;
  logic          ks_press, ks_rel, ks_clear;

  function automatic logic [NCOL-1:0] drive_one(input logic [CW-1:0] c,
                                                input logic [NCOL-1:0] en);
    logic [NCOL-1:0] oh;
    for (int i = 0; i < NCOL; i++) oh[i] = (CW'(i) == c);
    return ~(oh & en);
  endfunction

  assign key_idx = IW'(row_i) * IW'(NCOL) + IW'(col_i);

  kp_tick #(.DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .clr (st == ST_IDLE),
    .tc  (tick)
  );

  kp_keystate #(.NKEY(NKEY), .IW(IW)) u_keys (
    .clk       (clk),
    .rst       (rst),
    .upd       (st == ST_EVAL),
    .idx       (key_idx),
    .raw       (samp[row_i]),
    .press_o   (ks_press),
    .rel_o     (ks_rel),
    .all_clear (ks_clear)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      col_i     <= '0;
      row_i     <= '0;
      row_q     <= '1;
      samp      <= '0;
      col_drv_n <= '1;
      wake      <= 1'b0;
      evt_valid <= 1'b0;
      evt_press <= 1'b0;
      evt_code  <= '0;
    end else begin
      row_q     <= row_in;
      wake      <= 1'b0;
      evt_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          col_drv_n <= ~col_en;
          if (|(row_en & ~row_q)) begin
            st        <= ST_DRIVE;
            col_i     <= '0;
            col_drv_n <= drive_one('0, col_en);
            wake      <= 1'b1;
          end
        end
        ST_DRIVE: st <= ST_SAMPLE;
        ST_SAMPLE: begin
          samp  <= row_en & ~row_q & {NROW{col_en[col_i]}};
          row_i <= '0;
          st    <= ST_EVAL;
        end
        ST_EVAL: begin
          if (ks_press || ks_rel) begin
            evt_valid <= 1'b1;
            evt_press <= ks_press;
            evt_code  <= CODE_W'(key_idx) + CODE_W'(1);
          end
          if (row_i == RW'(NROW - 1)) begin
            if (col_i == CW'(NCOL - 1)) begin
              st        <= ST_END;
              col_drv_n <= '1;
            end else begin
              col_i     <= col_i + CW'(1);
              col_drv_n <= drive_one(col_i + CW'(1), col_en);
              st        <= ST_DRIVE;
            end
          end else begin
            row_i <= row_i + RW'(1);
          end
        end
        ST_END: begin
          if (ks_clear) begin
            st        <= ST_IDLE;
            col_drv_n <= ~col_en;
          end else begin
            st <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tick) begin
            st        <= ST_DRIVE;
            col_i     <= '0;
            col_drv_n <= drive_one('0, col_en);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kp_scanner_chk.sv
module kp_scanner_chk
  import kp_pkg::*;
#(
  parameter int NCOL   = 10,
  parameter int NKEY   = 80,
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst,
  input kp_state_t         st,
  input logic [NCOL-1:0]   col_en,
  input logic [NCOL-1:0]   col_drv_n,
  input logic              wake,
  input logic              evt_valid,
  input logic [CODE_W-1:0] evt_code
);
  // R6: code always within 1..NKEY
  p_code_range_r6: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> (evt_code >= CODE_W'(1) && evt_code <= CODE_W'(NKEY)));

  // R8: a sweep never drives two columns at once
  p_one_col_r8: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> ($countones(~col_drv_n) <= 1));

  // R2: wake is a single-cycle pulse
  p_wake_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake);

  // R2: steady idle drives exactly the enabled columns
  p_idle_drive_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && $past(st) == ST_IDLE && !$past(rst))
      |-> (col_drv_n == ~$past(col_en)));

  // R1: a masked column is never pulled low
  p_masked_col_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (&(col_drv_n | $past(col_en))));

  // R6: events only leave an active sweep, never with the wake pulse
  p_evt_active_r6: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> (st != ST_IDLE && !wake));
endmodule

bind kp_scanner kp_scanner_chk #(.NCOL(NCOL), .NKEY(NKEY), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .st        (st),
  .col_en    (col_en),
  .col_drv_n (col_drv_n),
  .wake      (wake),
  .evt_valid (evt_valid),
  .evt_code  (evt_code)
);

// File: tb/kp_scanner_tb.sv
module kp_scanner_tb;
  localparam int NR  = 8;
  localparam int NC  = 10;
  localparam int DIV = 128;
  localparam int S   = NR + 2;
  localparam int NK  = NR * NC;
  localparam int CWD = $clog2(NK + 1);

  logic           clk = 1'b0;
  logic           rst;
  logic [NR-1:0]  row_en;
  logic [NC-1:0]  col_en;
  logic [NR-1:0]  row_in;
  logic [NC-1:0]  col_drv_n;
  logic           wake, evt_valid, evt_press;
  logic [CWD-1:0] evt_code;
  logic [NK-1:0]  keys;

  int n_chk = 0, n_bad = 0, cyc = 0, wakes = 0;
  bit done = 1'b0;
  int ev_q[$];
  int ev_t[$];

  always #2 clk = ~clk;

  kp_scanner #(.NROW(NR), .NCOL(NC), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .row_en(row_en), .col_en(col_en), .row_in(row_in),
    .col_drv_n(col_drv_n), .wake(wake), .evt_valid(evt_valid),
    .evt_press(evt_press), .evt_code(evt_code)
  );

  // switch matrix: a row reads low when a closed key meets a low column
  always_comb begin
    for (int r = 0; r < NR; r++) begin
      row_in[r] = 1'b1;
      for (int c = 0; c < NC; c++)
        if (keys[r*NC+c] && !col_drv_n[c]) row_in[r] = 1'b0;
    end
  end

  // behavioural reference model
  bit m_idle, m_idrv, m_hit, exp_wake, exp_v, exp_p;
  int m_cnt, exp_code;
  bit [NK-1:0] m_prev, m_deb;
  bit [NR-1:0] m_samp;

  function automatic bit any_key();
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        if (keys[r*NC+c] && row_en[r] && col_en[c]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_idle = 1; m_idrv = 0; m_hit = 0; m_cnt = 0;
      m_prev = '0; m_deb = '0; exp_wake = 0; exp_v = 0; exp_p = 0; exp_code = 0;
    end else begin
      bit hit_new;
      hit_new  = m_idrv && any_key();
      exp_wake = 0;
      exp_v    = 0;
      if (m_idle) begin
        if (m_hit) begin
          exp_wake = 1; m_idle = 0; m_cnt = 0; m_idrv = 0;
        end else m_idrv = 1;
      end else begin
        if (m_cnt < NC*S) begin
          int c, ph;
          c  = m_cnt / S;
          ph = m_cnt % S;
          if (ph == 0) begin
            for (int r = 0; r < NR; r++) m_samp[r] = keys[r*NC+c] && row_en[r] && col_en[c];
          end else if (ph >= 2) begin
            int r, k;
            bit raw;
            r = ph - 2; k = r*NC + c; raw = m_samp[r];
            if (raw && m_prev[k] && !m_deb[k]) begin
              m_deb[k] = 1; exp_v = 1; exp_p = 1; exp_code = k + 1;
            end else if (!raw && !m_prev[k] && m_deb[k]) begin
              m_deb[k] = 0; exp_v = 1; exp_p = 0; exp_code = k + 1;
            end
            m_prev[k] = raw;
          end
        end else if (m_cnt == NC*S) begin
          if (m_deb == '0 && m_prev == '0) begin m_idle = 1; m_idrv = 1; end
        end
        m_cnt = (m_cnt == DIV-1) ? 0 : m_cnt + 1;
      end
      m_hit = hit_new;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-clock comparison and event capture
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(wake == exp_wake, "R2 wake timing", int'(wake), int'(exp_wake));
      chk(evt_valid == exp_v, "R6 event strobe", int'(evt_valid), int'(exp_v));
      if (exp_v && evt_valid)
        chk({evt_press, evt_code} == {exp_p, CWD'(exp_code)}, "R6 event content",
            int'(evt_press)*256 + int'(evt_code), int'(exp_p)*256 + exp_code);
      if (evt_valid) begin
        ev_q.push_back(int'(evt_press)*256 + int'(evt_code));
        ev_t.push_back(cyc);
      end
      if (wake) wakes++;
    end
  end

  function automatic int ev(input int p, input int code);
    return p*256 + code;
  endfunction

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    for (int i = 0; i < 30*DIV && !m_idle; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic hold(input int k1, input int k2, input int n);
    keys[k1] = 1'b1;
    if (k2 >= 0) keys[k2] = 1'b1;
    repeat (n) @(negedge clk);
    keys[k1] = 1'b0;
    if (k2 >= 0) keys[k2] = 1'b0;
    wait_idle();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    rst = 1'b1; keys = '0; row_en = '1; col_en = '1;
    repeat (4) @(negedge clk);
    chk(col_drv_n == '1 && !evt_valid && !wake, "R2 reset state", int'(col_drv_n), 1023);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(col_drv_n == ~col_en, "R2 idle drive", int'(col_drv_n), int'(~col_en));

    // R4 R5 R6: single key r1c1 held five periods
    ev_q.delete(); ev_t.delete();
    hold(1*NC+1, -1, 5*DIV);
    chk(ev_q.size() == 2, "R4 one press one release", ev_q.size(), 2);
    chk(ev_q[0] == ev(1, 12), "R6 press code 12", ev_q[0], ev(1, 12));
    chk(ev_q[1] == ev(0, 12), "R5 release code 12", ev_q[1], ev(0, 12));
    chk(col_drv_n == ~col_en, "R8 back to idle drive", int'(col_drv_n), int'(~col_en));

    // R7: two keys in one sweep, column order
    ev_q.delete(); ev_t.delete();
    hold(2*NC+3, 0*NC+5, 3*DIV);
    chk(ev_q.size() == 4, "R7 event count", ev_q.size(), 4);
    chk(ev_q[0] == ev(1, 24) && ev_q[1] == ev(1, 6), "R7 press order", ev_q[0], ev(1, 24));
    chk(ev_q[2] == ev(0, 24) && ev_q[3] == ev(0, 6), "R7 release order", ev_q[2], ev(0, 24));

    // R3: single-sweep glitch gives wake but no event
    ev_q.delete(); ev_t.delete();
    begin
      int w0;
      w0 = wakes;
      hold(0, -1, 40);
      chk(wakes == w0 + 1, "R3 glitch wakes once", wakes - w0, 1);
      chk(ev_q.size() == 0, "R3 glitch no event", ev_q.size(), 0);
      chk(col_drv_n == ~col_en, "R8 idle after glitch", int'(col_drv_n), int'(~col_en));
    end

    // R1: masked row and column
    ev_q.delete(); ev_t.delete();
    col_en[7] = 1'b0; row_en[6] = 1'b0;
    repeat (4) @(negedge clk);
    chk(col_drv_n[7] == 1'b1, "R1 masked column released", int'(col_drv_n[7]), 1);
    begin
      int w0;
      w0 = wakes;
      hold(0*NC+7, 6*NC+2, 3*DIV);
      chk(wakes == w0, "R1 no wake from masked lines", wakes - w0, 0);
      chk(ev_q.size() == 0, "R1 no event from masked lines", ev_q.size(), 0);
    end
    col_en = '1; row_en = '1;
    repeat (4) @(negedge clk);

    // R6 R7: extreme codes 1 and 80
    ev_q.delete(); ev_t.delete();
    hold(7*NC+9, 0, 2*DIV);
    chk(ev_q.size() == 4, "R6 corner event count", ev_q.size(), 4);
    chk(ev_q[0] == ev(1, 1) && ev_q[1] == ev(1, 80), "R6 codes 1 and 80", ev_q[1], ev(1, 80));
    chk(ev_q[2] == ev(0, 1) && ev_q[3] == ev(0, 80), "R7 corner release order", ev_q[3], ev(0, 80));

    // R3 R5: latency bounds for key r3c4 (code 35)
    ev_q.delete(); ev_t.delete();
    begin
      int t0, t1;
      t0 = cyc;
      keys[3*NC+4] = 1'b1;
      repeat (3*DIV + 17) @(negedge clk);
      keys[3*NC+4] = 1'b0;
      t1 = cyc;
      wait_idle();
      chk(ev_q.size() == 2 && ev_q[0] == ev(1, 35), "R3 press code 35", ev_q[0], ev(1, 35));
      chk(ev_t[0] - t0 >= DIV && ev_t[0] - t0 <= DIV + NC*S + 8, "R3 press latency",
          ev_t[0] - t0, DIV);
      chk(ev_t[1] - t1 >= DIV && ev_t[1] - t1 <= 2*DIV + S + 8, "R5 release latency",
          ev_t[1] - t1, DIV);
    end

    // R7: one key opens while another closes, both reported in one sweep
    ev_q.delete(); ev_t.delete();
    keys[4*NC+6] = 1'b1;
    repeat (2*DIV + 5) @(negedge clk);
    keys[4*NC+6] = 1'b0;
    keys[1*NC+2] = 1'b1;
    repeat (3*DIV) @(negedge clk);
    keys[1*NC+2] = 1'b0;
    wait_idle();
    chk(ev_q.size() == 4, "R7 swap event count", ev_q.size(), 4);
    chk(ev_q[1] == ev(1, 13) && ev_q[2] == ev(0, 47), "R7 press before release in sweep",
        ev_q[1], ev(1, 13));
    chk(ev_t[2] - ev_t[1] < NC*S, "R7 same sweep", ev_t[2] - ev_t[1], NC*S);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      summary();
      $finish;
    end
  end
endmodule